// File: doc/BRIEF.md
# Flash Mailbox Command Engine

This block is the device side of a register mailbox. Software reaches it through a 32-bit register port addressed by dword offset. The port exposes three things: a 16-dword data window, a command register and a status register. Software loads the window and then writes a command word with its request bit set. The engine then spends a fixed number of busy cycles on the command.

When the command finishes, the engine moves data between the window and a small internal flash-like array. It then clears the request bit and posts a status word that echoes the command code. The command set covers flash read, flash write, update-authenticate and power cycle. The last two are stubs: each completes after the same fixed latency and has no side effect.

Software polls the request bit to learn when a command has completed. It then reads the status register for the result, and reads the window for data.

Top module: `mbox_engine`

## Requirements
- R1: After reset, every register offset reads zero: the window, the command register at offset 17 and the status register at offset 18.
- R2: Offsets 1 to 16 are the data window, so window dword k sits at offset k+1 and can be written and read back. Offsets 0 and 19 and above read zero.
- R3: A write to offset 17 with bit 0 set, made while bit 0 is clear, starts a command. Bit 0 reads 1 until exactly BUSY_CYCLES clock edges after the accepting edge, then reads 0. Bits 31:1 keep the value written.
- R4: While bit 0 of the command register is set, writes to the command register and to the window are ignored.
- R5: At completion, status takes the following form. Bit 29 is 1, bits 7:4 hold the command code (bits 31:28 of the command), bits 3:0 hold the result code (0 done, 2 access error), and every other bit is 0. Status changes at no other time, and writes to offset 18 are ignored.
- R6: Command code 0x2 is flash read. Starting at the dword address in bits 23:2, it copies n dwords of the array into window dwords 0..n-1. The count field in bits 27:24 gives n, with 0 meaning 16. The other window dwords are left as they were.
- R7: Command code 0x0 is flash write. It copies window dwords 0..c into the array, starting at the dword address in bits 23:2. Here c is the count field, so the field holds the dword count minus one.
- R8: For a write with bit 1 set, the destination is the fixed header dword address HDR_DWORD, whatever the address field holds.
- R9: A read or write with start + n > FLASH_DWORDS posts result code 2 and changes neither the array nor the window.
- R10: Code 0x1 (update-authenticate) and code 0x4 (power cycle) complete with result 0 and change no data.
- R11: Any other command code completes with result 2 and changes no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Dword offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |

## Verification
A wrong busy counter shows up as a request bit that clears one or more polls early or late. The bench counts every poll on every command, so it sees this at once. A bad address or count decode only appears at the ports once the array is read back: wrong or missing dwords land in the window one command later. For that reason, every write, CSS write and rejected access is followed by a read-back command. A status field that is wrong or stale shows up on the first status read after completion. Writes that leak in while the engine is busy show up in the command, status and window values read once the request bit clears.

// File: rtl/mbox_engine.sv
module mbox_engine #(
  parameter int FLASH_DWORDS = 64,
  parameter int HDR_DWORD    = 56,
  parameter int BUSY_CYCLES  = 5,
  parameter int REG_AW       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int WIN      = 16;
  localparam int WIN_BASE = 1;
  localparam int CMD_OFS  = WIN_BASE + WIN;
  localparam int STS_OFS  = CMD_OFS + 1;
  localparam int FAW      = $clog2(FLASH_DWORDS);
  localparam int CW       = $clog2(BUSY_CYCLES + 1);
  localparam logic [3:0] OP_WR = 4'h0, OP_AUTH = 4'h1, OP_RD = 4'h2, OP_PWR = 4'h4;

  logic [31:0] win   [WIN];
  logic [31:0] flash [FLASH_DWORDS];
  logic [31:0] cmd_q, status_q;
  logic [CW-1:0] cnt_q;

  wire        busy   = cmd_q[0];
  wire [3:0]  op     = cmd_q[31:28];
  wire [3:0]  cnt_f  = cmd_q[27:24];
  wire [21:0] addr_f = cmd_q[23:2];
  wire        css    = cmd_q[1];
  wire        is_rd  = (op == OP_RD);
  wire        is_wr  = (op == OP_WR);
  wire        fire   = busy && (cnt_q == CW'(1));

  wire [4:0]  nxfer  = is_wr ? ({1'b0, cnt_f} + 5'd1) : ((cnt_f == 4'd0) ? 5'd16 : {1'b0, cnt_f});
  wire [21:0] base   = (is_wr && css) ? 22'(HDR_DWORD) : addr_f;
  wire [22:0] span   = {1'b0, base} + 23'(nxfer);
  wire        in_rng = (span <= 23'(FLASH_DWORDS));
  wire [FAW-1:0] fbase = base[FAW-1:0];

  wire        win_hit = (reg_addr >= REG_AW'(WIN_BASE)) && (reg_addr < REG_AW'(CMD_OFS));
  wire [3:0]  widx    = 4'(reg_addr - REG_AW'(WIN_BASE));
  wire        sw_ok   = reg_we && !busy;

  logic [3:0] code;
  always_comb begin
    case (op)
      OP_AUTH, OP_PWR: code = 4'd0;
      OP_WR, OP_RD:    code = in_rng ? 4'd0 : 4'd2;
      default:         code = 4'd2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FLASH_DWORDS; i++) flash[i] <= '0;
    end else if (fire && is_wr && in_rng) begin
      for (int i = 0; i < WIN; i++)
        if (5'(i) < nxfer) flash[fbase + FAW'(i)] <= win[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) win[i] <= '0;
    end else if (fire && is_rd && in_rng) begin
      for (int i = 0; i < WIN; i++)
        if (5'(i) < nxfer) win[i] <= flash[fbase + FAW'(i)];
    end else if (sw_ok && win_hit) begin
      win[widx] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      status_q <= '0;
      cnt_q    <= '0;
    end else if (sw_ok && reg_addr == REG_AW'(CMD_OFS)) begin
      cmd_q <= reg_wdata;
      cnt_q <= CW'(BUSY_CYCLES);
    end else if (fire) begin
      cmd_q[0] <= 1'b0;
      status_q <= {2'b00, 1'b1, 21'd0, op, code};
    end else if (busy) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  always_comb begin
    if (win_hit)                          reg_rdata = win[widx];
    else if (reg_addr == REG_AW'(CMD_OFS)) reg_rdata = cmd_q;
    else if (reg_addr == REG_AW'(STS_OFS)) reg_rdata = status_q;
    else                                  reg_rdata = '0;
  end
endmodule

module mbox_engine_chk #(
  parameter int BUSY_CYCLES = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cmd_q,
  input logic [31:0] status_q
);
  logic [15:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= '0;
    else if (cmd_q[0]) run_q <= run_q + 16'd1;
    else               run_q <= '0;
  end

  wire [3:0] op = cmd_q[31:28];
  wire known = (op == 4'h0) || (op == 4'h1) || (op == 4'h2) || (op == 4'h4);

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_q[0]) |-> run_q == 16'(BUSY_CYCLES)); // R3
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[0] |=> cmd_q[31:1] == $past(cmd_q[31:1])); // R4
  AST_STATUS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cmd_q[0]) |-> $stable(status_q)); // R5
  AST_STATUS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_q[0]) |-> (status_q[29] && status_q[7:4] == op &&
                         status_q[31:30] == 2'b0 && status_q[28:8] == 21'd0)); // R5
  AST_STUB_OK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cmd_q[0]) && (op == 4'h1 || op == 4'h4)) |-> status_q[3:0] == 4'd0); // R10
  AST_UNKNOWN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cmd_q[0]) && !known) |-> status_q[3:0] == 4'd2); // R11
endmodule

bind mbox_engine mbox_engine_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_q(cmd_q), .status_q(status_q)
);

// File: tb/mbox_engine_tb.sv
`timescale 1ns/1ps
module mbox_engine_tb;
  localparam int BUSY = 5;
  localparam int FLASH = 64;
  localparam int HDR = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mon_vld = 1'b0;
  logic done = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  mbox_engine #(.FLASH_DWORDS(FLASH), .HDR_DWORD(HDR), .BUSY_CYCLES(BUSY), .REG_AW(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] pat(int i);
    return 32'hA500_0000 + 32'(i) * 32'h11;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic expect_rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk); reg_addr = a; exp_q.push_back(e); tag_q.push_back(t); mon_vld = 1'b1;
    @(negedge clk); mon_vld = 1'b0;
  endtask

  task automatic run_cmd(input logic [31:0] c);
    int k;
    @(negedge clk); reg_we = 1'b1; reg_addr = 5'd17; reg_wdata = c;
    @(negedge clk); reg_we = 1'b0; reg_addr = 5'd17;
    k = 0;
    while (reg_rdata[0] && k < 1000) begin k++; @(negedge clk); end
    n_cmp++;
    if (k != BUSY) begin
      n_bad++;
      $display("FAIL R3: busy polls got %0d exp %0d (cmd %h)", k, BUSY, c);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (mon_vld && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (reg_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: offset %0d got %h exp %h", t, reg_addr, reg_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish got hung exp done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    expect_rd(5'd1, 32'h0, "R1");
    expect_rd(5'd16, 32'h0, "R1");
    expect_rd(5'd17, 32'h0, "R1");
    expect_rd(5'd18, 32'h0, "R1");

    for (int i = 0; i < 16; i++) wr(5'(1 + i), pat(i));
    expect_rd(5'd1, pat(0), "R2");
    expect_rd(5'd16, pat(15), "R2");
    expect_rd(5'd0, 32'h0, "R2");
    expect_rd(5'd19, 32'h0, "R2");
    expect_rd(5'd31, 32'h0, "R2");

    run_cmd(32'h0F00_0011);
    expect_rd(5'd18, 32'h2000_0000, "R7");
    expect_rd(5'd17, 32'h0F00_0010, "R3");

    for (int i = 0; i < 16; i++) wr(5'(1 + i), 32'h0);
    run_cmd(32'h2000_0011);
    expect_rd(5'd18, 32'h2000_0020, "R5");
    for (int i = 0; i < 16; i++) expect_rd(5'(1 + i), pat(i), "R6");

    for (int i = 0; i < 16; i++) wr(5'(1 + i), 32'hFFFF_FFFF);
    run_cmd(32'h2300_0015);
    expect_rd(5'd1, pat(1), "R6");
    expect_rd(5'd2, pat(2), "R6");
    expect_rd(5'd3, pat(3), "R6");
    expect_rd(5'd4, 32'hFFFF_FFFF, "R6");
    expect_rd(5'd16, 32'hFFFF_FFFF, "R6");

    run_cmd(32'h0300_00F9);
    expect_rd(5'd18, 32'h2000_0002, "R9");
    run_cmd(32'h2200_00F9);
    expect_rd(5'd18, 32'h2000_0020, "R9");
    expect_rd(5'd1, 32'h0, "R9");
    expect_rd(5'd2, 32'h0, "R9");

    wr(5'd1, 32'h0000_1234);
    run_cmd(32'h2400_00F9);
    expect_rd(5'd18, 32'h2000_0022, "R9");
    expect_rd(5'd1, 32'h0000_1234, "R9");

    wr(5'd1, 32'hC55C_0001);
    run_cmd(32'h0000_0003);
    expect_rd(5'd18, 32'h2000_0000, "R8");
    run_cmd(32'h2100_00E1);
    expect_rd(5'd1, 32'hC55C_0001, "R8");
    run_cmd(32'h2100_0001);
    expect_rd(5'd1, 32'h0, "R8");

    wr(5'd1, 32'h0000_ABCD);
    run_cmd(32'h1000_0001);
    expect_rd(5'd18, 32'h2000_0010, "R10");
    expect_rd(5'd1, 32'h0000_ABCD, "R10");
    run_cmd(32'h4000_0001);
    expect_rd(5'd18, 32'h2000_0040, "R10");

    run_cmd(32'h7000_0001);
    expect_rd(5'd18, 32'h2000_0072, "R11");
    expect_rd(5'd1, 32'h0000_ABCD, "R11");

    wr(5'd18, 32'hFFFF_FFFF);
    expect_rd(5'd18, 32'h2000_0072, "R5");

    @(negedge clk); reg_we = 1'b1; reg_addr = 5'd17; reg_wdata = 32'h2100_0011;
    @(negedge clk); reg_wdata = 32'h7000_0001;
    @(negedge clk); reg_addr = 5'd1; reg_wdata = 32'h0000_DEAD;
    @(negedge clk); reg_we = 1'b0;
    repeat (BUSY + 2) @(negedge clk);
    expect_rd(5'd17, 32'h2100_0010, "R4");
    expect_rd(5'd18, 32'h2000_0020, "R4");
    expect_rd(5'd1, pat(0), "R4");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule